// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execution Unit

This unit carries out the second opcode page of an 8-bit processor: the page that is entered after a prefix byte. Once the main core has recognised the prefix, it pulses `start` with the current program counter and the HL pointer on the inputs. The unit fetches the second opcode byte from memory at that program counter and decodes it. It then performs a rotate or shift, a single-bit test, a single-bit clear or a single-bit set. The target is one of seven 8-bit registers or the byte in memory addressed by HL.

A register target is read and written through a combinational register-file port. A memory target goes through a fixed-latency memory port. For a rotate, shift, clear or set, this is a read-modify-write to the same address. For a bit test, it is a read alone. On its final cycle the unit raises `done` for one cycle. In that cycle it presents the advanced program counter, any flag update and the cycle cost that the instruction is charged: 8, 12 or 15.

Memory reads return data on the clock edge after `mem_rd`. The register file is read combinationally through `reg_sel`.

Top module: `pfx_bitops_unit`

## Requirements
- R1: While reset is applied, and after it is released with `start` low, `mem_rd`, `mem_we`, `reg_we`, `flags_we` and `done` are all low.
- R2: In the first cycle after `start` is accepted, the unit raises `mem_rd` for exactly one cycle with `mem_addr` equal to the captured program counter. In the `done` cycle, `pc_next` equals that program counter plus one.
- R3: The fetched opcode is split into fields. Bits 7:6 select the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Bits 5:3 give the shift kind or the bit index. Bits 2:0 give the target: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at HL, 7 A. A register write uses `reg_sel` equal to the target code.
- R4: The shift kinds 0 to 7 are: rotate left circular, rotate right circular, rotate left through carry, rotate right through carry, arithmetic left, arithmetic right (bit 7 kept), logical left with a one in, and logical right. Each one writes carry (flag bit 0) with the bit shifted out. It sets sign (bit 7) from result bit 7 and zero (bit 6) when the result is 0. It sets parity (bit 2) when the result has an even number of ones. It clears half-carry (bit 4) and subtract (bit 1), and copies flag bits 5 and 3 from `flags_in`.
- R5: Shift kind 6 (logical left) moves a 1 into result bit 0, so an input of 0x00 yields 0x01 with carry 0.
- R6: A bit test sets zero and parity to the inverse of the tested bit, sets half-carry and clears subtract. It leaves carry and bits 5 and 3 as in `flags_in`. Sign is set only when bit 7 is the one tested and it is 1. No register or memory write takes place.
- R7: A bit clear or bit set changes only the indexed bit of the target, and leaves `flags_we` low.
- R8: A register-target instruction raises `done` in the third cycle after `start` is accepted, with `cyc_cost` equal to 8. The register write and the flag update occur in that same cycle.
- R9: A rotate/shift, clear or set on the memory target raises `mem_rd` at HL in the third cycle. In the fourth cycle it raises `done` and `mem_we`, writing the transformed byte to that same HL address, with `cyc_cost` equal to 15.
- R10: A bit test on the memory target reads HL in the third cycle and completes in the fourth with `cyc_cost` equal to 12. It raises no `mem_we` and no `reg_we`.
- R11: `start` is ignored while an instruction is in progress. Holding it high after acceptance causes no second fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Prefix seen; begin a second-page instruction (accepted when idle) |
| pc_in | input | ADDR_W | Program counter pointing at the second opcode byte |
| hl_in | input | ADDR_W | HL pointer for the memory target |
| flags_in | input | 8 | Current flag byte |
| reg_rdata | input | DATA_W | Register-file read data for `reg_sel` |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_rd` |
| reg_sel | output | 3 | Register-file select (target code) |
| reg_we | output | 1 | Register-file write strobe |
| reg_wdata | output | DATA_W | Register-file write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 8 | New flag byte |
| done | output | 1 | Final cycle of the instruction |
| pc_next | output | ADDR_W | Advanced program counter, valid with `done` |
| cyc_cost | output | COST_W | Cycle cost of the instruction, valid with `done` |

## Verification
In the final cycle of a memory read-modify-write, the write-back of the transformed byte and the flag update happen together. A register instruction likewise combines the register write with the flag update. The bench provokes both cases by running every one of the 256 opcodes against a memory byte and register values that keep changing, with a varied incoming flag byte. A cycle-by-cycle model predicts, for every cycle, which strobes are high and what data, address and flags they carry. A write without its flags, or flags without its write, shows up as a mismatch in that cycle. A separate pass holds `start` high across a busy instruction to judge that the fetch and write strobes still occur only once.

// File: rtl/pfx_bitops_pkg.sv
package pfx_bitops_pkg;

  localparam int FLAG_W = 8;
  localparam int SEL_W  = 3;

  // flag byte bit positions
  localparam int FL_S  = 7;
  localparam int FL_Z  = 6;
  localparam int FL_H  = 4;
  localparam int FL_PV = 2;
  localparam int FL_N  = 1;
  localparam int FL_C  = 0;
  localparam logic [FLAG_W-1:0] FL_KEEP = 8'h28;

  localparam logic [SEL_W-1:0] OPND_MEM = 3'd6;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SETB  = 2'b11
  } grp_e;

  typedef enum logic [SEL_W-1:0] {
    SH_ROLC = 3'd0,
    SH_RORC = 3'd1,
    SH_ROLT = 3'd2,
    SH_RORT = 3'd3,
    SH_ASL  = 3'd4,
    SH_ASR  = 3'd5,
    SH_LSL1 = 3'd6,
    SH_LSR  = 3'd7
  } shk_e;

  typedef struct packed {
    grp_e             grp;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] opnd;
    logic             mem;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_EXEC,
    ST_MRD,
    ST_MEXEC
  } st_e;

endpackage

// File: rtl/pfx_bitops_decode.sv
module pfx_bitops_decode
  import pfx_bitops_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);

  always_comb begin
    dec.grp  = grp_e'(op[OP_W-1 -: 2]);
    dec.sel  = op[5:3];
    dec.opnd = op[2:0];
    dec.mem  = (op[2:0] == OPND_MEM);
  end

endmodule

// File: rtl/pfx_bitops_alu.sv
module pfx_bitops_alu
  import pfx_bitops_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dec_t              dec,
  input  logic [DATA_W-1:0] opnd_val,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_res
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] sh_res;
  logic              sh_out;
  logic              tested;

  // one-hot bit mask from the index field
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (32'(dec.sel) == g);
    end
  endgenerate

  assign tested = |(opnd_val & mask);

  always_comb begin
    sh_res = opnd_val;
    sh_out = 1'b0;
    case (shk_e'(dec.sel))
      SH_ROLC: begin sh_res = {opnd_val[MSB-1:0], opnd_val[MSB]};   sh_out = opnd_val[MSB]; end
      SH_RORC: begin sh_res = {opnd_val[0], opnd_val[MSB:1]};       sh_out = opnd_val[0];   end
      SH_ROLT: begin sh_res = {opnd_val[MSB-1:0], flags_in[FL_C]};  sh_out = opnd_val[MSB]; end
      SH_RORT: begin sh_res = {flags_in[FL_C], opnd_val[MSB:1]};    sh_out = opnd_val[0];   end
      SH_ASL:  begin sh_res = {opnd_val[MSB-1:0], 1'b0};            sh_out = opnd_val[MSB]; end
      SH_ASR:  begin sh_res = {opnd_val[MSB], opnd_val[MSB:1]};     sh_out = opnd_val[0];   end
      SH_LSL1: begin sh_res = {opnd_val[MSB-1:0], 1'b1};            sh_out = opnd_val[MSB]; end
      SH_LSR:  begin sh_res = {1'b0, opnd_val[MSB:1]};              sh_out = opnd_val[0];   end
      default: begin sh_res = opnd_val;                             sh_out = 1'b0;          end
    endcase
  end

  always_comb begin
    result    = opnd_val;
    flags_res = flags_in;
    case (dec.grp)
      GRP_SHIFT: begin
        result           = sh_res;
        flags_res        = flags_in & FL_KEEP;
        flags_res[FL_S]  = sh_res[MSB];
        flags_res[FL_Z]  = (sh_res == '0);
        flags_res[FL_PV] = ~^sh_res;
        flags_res[FL_C]  = sh_out;
      end
      GRP_TEST: begin
        result           = opnd_val;
        flags_res        = flags_in & FL_KEEP;
        // top-bit test is the only one that can raise sign
        flags_res[FL_S]  = tested & mask[MSB];
        flags_res[FL_Z]  = ~tested;
        flags_res[FL_H]  = 1'b1;
        flags_res[FL_PV] = ~tested;
        flags_res[FL_N]  = 1'b0;
        flags_res[FL_C]  = flags_in[FL_C];
      end
      GRP_CLR:  result = opnd_val & ~mask;
      GRP_SETB: result = opnd_val | mask;
      default:  result = opnd_val;
    endcase
  end

endmodule

// File: rtl/pfx_bitops_seq.sv
module pfx_bitops_seq
  import pfx_bitops_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lat_is_mem,
  output st_e  state
);

  st_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_LATCH;
      ST_LATCH: state_d = lat_is_mem ? ST_MRD : ST_EXEC;
      ST_EXEC:  state_d = ST_IDLE;
      ST_MRD:   state_d = ST_MEXEC;
      ST_MEXEC: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/pfx_bitops_unit.sv
module pfx_bitops_unit
  import pfx_bitops_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int CYC_REG    = 8,
  parameter int CYC_BITMEM = 12,
  parameter int CYC_RMW    = 15,
  localparam int COST_W    = $clog2(CYC_RMW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] hl_in,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              flags_we,
  output logic [FLAG_W-1:0] flags_out,
  output logic              done,
  output logic [ADDR_W-1:0] pc_next,
  output logic [COST_W-1:0] cyc_cost
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  st_e               state;
  dec_t              dec, dec_lat;
  logic [ADDR_W-1:0] pc_q, pc_d, hl_q, hl_d;
  logic [DATA_W-1:0] op_q, op_d;
  logic [DATA_W-1:0] opnd_val, alu_res;
  logic [FLAG_W-1:0] alu_flags;
  logic              ld_ctx, ld_op, is_test;

  pfx_bitops_decode #(.OP_W(DATA_W)) u_dec_lat (.op(mem_rdata), .dec(dec_lat));
  pfx_bitops_decode #(.OP_W(DATA_W)) u_dec     (.op(op_q),      .dec(dec));

  pfx_bitops_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .lat_is_mem (dec_lat.mem),
    .state      (state)
  );

  assign opnd_val = dec.mem ? mem_rdata : reg_rdata;

  pfx_bitops_alu #(.DATA_W(DATA_W)) u_alu (
    .dec       (dec),
    .opnd_val  (opnd_val),
    .flags_in  (flags_in),
    .result    (alu_res),
    .flags_res (alu_flags)
  );

  // context and opcode capture
  assign ld_ctx = (state == ST_IDLE) && start;
  assign ld_op  = (state == ST_LATCH);

  always_comb begin
    pc_d = pc_q;
    hl_d = hl_q;
    op_d = op_q;
    if (ld_ctx) begin
      pc_d = pc_in;
      hl_d = hl_in;
    end
    if (ld_op) op_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
      hl_q <= '0;
      op_q <= '0;
    end else begin
      pc_q <= pc_d;
      hl_q <= hl_d;
      op_q <= op_d;
    end
  end

  // outputs per state
  assign is_test = (dec.grp == GRP_TEST);

  always_comb begin
    mem_rd   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = hl_q;
    reg_we   = 1'b0;
    flags_we = 1'b0;
    done     = 1'b0;
    cyc_cost = '0;
    case (state)
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q;
      end
      ST_EXEC: begin
        done     = 1'b1;
        reg_we   = !is_test;
        flags_we = (dec.grp == GRP_SHIFT) || is_test;
        cyc_cost = COST_W'(CYC_REG);
      end
      ST_MRD: mem_rd = 1'b1;
      ST_MEXEC: begin
        done     = 1'b1;
        mem_we   = !is_test;
        flags_we = (dec.grp == GRP_SHIFT) || is_test;
        cyc_cost = is_test ? COST_W'(CYC_BITMEM) : COST_W'(CYC_RMW);
      end
      default: ;
    endcase
  end

  assign reg_sel   = dec.opnd;
  assign reg_wdata = alu_res;
  assign mem_wdata = alu_res;
  assign flags_out = alu_flags;
  assign pc_next   = pc_q + ADDR_W'(1);

endmodule

// File: rtl/pfx_bitops_chk.sv
module pfx_bitops_chk #(
  parameter int COST_W     = 4,
  parameter int CYC_REG    = 8,
  parameter int CYC_BITMEM = 12,
  parameter int CYC_RMW    = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              reg_we,
  input logic              flags_we,
  input logic              done,
  input logic [COST_W-1:0] cyc_cost
);

  // R2: memory reads never stand in two consecutive cycles
  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R3: read, memory write and register write never overlap
  assert_port_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_we, reg_we}));

  // R8: completion lasts exactly one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: charged cost is one of the three legal values
  assert_cost_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_cost == COST_W'(CYC_REG) || cyc_cost == COST_W'(CYC_BITMEM) ||
              cyc_cost == COST_W'(CYC_RMW)));

  // R9: write-back to memory only in the completion cycle, after a read
  assert_wb_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (done && $past(mem_rd)));

  // R10: memory bit test writes nothing
  assert_test_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cyc_cost == COST_W'(CYC_BITMEM)) |-> (!mem_we && !reg_we && flags_we));

  // R7: an instruction that completes without a flag update must store a result
  assert_noflag_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flags_we) |-> (mem_we || reg_we));

endmodule

bind pfx_bitops_unit pfx_bitops_chk #(
  .COST_W     (COST_W),
  .CYC_REG    (CYC_REG),
  .CYC_BITMEM (CYC_BITMEM),
  .CYC_RMW    (CYC_RMW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .mem_rd   (mem_rd),
  .mem_we   (mem_we),
  .reg_we   (reg_we),
  .flags_we (flags_we),
  .done     (done),
  .cyc_cost (cyc_cost)
);

// File: tb/pfx_bitops_unit_bench.sv
`timescale 1ns/1ps
module pfx_bitops_unit_bench;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam logic [AW-1:0] HL = 16'hC0A5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] pc_in, hl_in;
  logic [7:0]    flags_in;
  logic [DW-1:0] reg_rdata, mem_rdata;
  logic [2:0]    reg_sel;
  logic          reg_we, mem_rd, mem_we, flags_we, done;
  logic [DW-1:0] reg_wdata, mem_wdata;
  logic [AW-1:0] mem_addr, pc_next;
  logic [7:0]    flags_out;
  logic [CW-1:0] cyc_cost;

  always #2 clk = ~clk;

  pfx_bitops_unit u_pfx_bitops_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .hl_in(hl_in),
    .flags_in(flags_in), .reg_rdata(reg_rdata), .mem_rdata(mem_rdata),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .flags_we(flags_we), .flags_out(flags_out), .done(done),
    .pc_next(pc_next), .cyc_cost(cyc_cost)
  );

  // storage seen by the design
  logic [7:0] mem  [256];
  logic [7:0] regs [8];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (reg_we) regs[reg_sel] <= reg_wdata;
  end
  assign reg_rdata = regs[reg_sel];

  // reference state
  int m_mem  [256];
  int m_regs [8];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int even_par(input int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) ones++;
    return (ones % 2 == 0) ? 1 : 0;
  endfunction

  task automatic set_reg(input int idx, input int val);
    regs[idx]   = val[7:0];
    m_regs[idx] = val;
  endtask

  task automatic run_op(input logic [7:0] op, input logic [7:0] fin,
                        input logic [15:0] pc, input bit hold);
    int grp    = int'(op[7:6]);
    int kind   = int'(op[5:3]);
    int tgt    = int'(op[2:0]);
    bit is_mem = (tgt == 6);
    int x      = is_mem ? m_mem[HL[7:0]] : m_regs[tgt];
    int cin    = int'(fin[0]);
    int r      = x;
    int cout   = 0;
    int ef     = int'(fin);
    int last   = is_mem ? 4 : 3;
    bit tb;
    string tag_t, tag_d;

    if (grp == 0) begin
      case (kind)
        0: begin r = ((x * 2) + (x / 128)) % 256; cout = x / 128; end
        1: begin r = (x / 2) + ((x % 2) * 128);   cout = x % 2;   end
        2: begin r = ((x * 2) % 256) + cin;       cout = x / 128; end
        3: begin r = (x / 2) + cin * 128;         cout = x % 2;   end
        4: begin r = (x * 2) % 256;               cout = x / 128; end
        5: begin r = (x / 2) + (x & 128);         cout = x % 2;   end
        6: begin r = ((x * 2) % 256) + 1;         cout = x / 128; end
        default: begin r = x / 2;                 cout = x % 2;   end
      endcase
      ef = (int'(fin) & 'h28) | ((r >= 128) ? 'h80 : 0) | ((r == 0) ? 'h40 : 0)
           | (even_par(r) ? 'h04 : 0) | cout;
      tag_d = (kind == 6) ? "R5" : "R4";
    end else if (grp == 1) begin
      tb = ((x >> kind) & 1) != 0;
      ef = (int'(fin) & 'h29) | 'h10 | ((kind == 7 && tb) ? 'h80 : 0)
           | (!tb ? 'h44 : 0);
      tag_d = "R6";
    end else begin
      r = (grp == 2) ? (x & ~(1 << kind) & 255) : (x | (1 << kind));
      tag_d = "R7";
    end

    mem[pc[7:0]]   = op;
    m_mem[pc[7:0]] = int'(op);
    pc_in    = pc;
    hl_in    = HL;
    flags_in = fin;
    start    = 1'b1;
    tag_t = hold ? "R11" : (is_mem ? ((grp == 1) ? "R10" : "R9") : "R8");

    for (int k = 1; k <= last + 1; k++) begin
      bit e_rd, e_done, e_mwe, e_rwe, e_fwe;
      @(negedge clk);
      if (!hold || k == 3) start = 1'b0;
      e_rd   = (k == 1) || (is_mem && k == 3);
      e_done = (k == last);
      e_mwe  = e_done && is_mem && grp != 1;
      e_rwe  = e_done && !is_mem && grp != 1;
      e_fwe  = e_done && grp <= 1;
      chk(tag_t, $sformatf("op %02h cyc %0d strobes", op, k),
          int'({mem_rd, mem_we, reg_we, flags_we, done}),
          int'({e_rd, e_mwe, e_rwe, e_fwe, e_done}));
      if (e_rd && k == 1) chk("R2", "fetch addr", int'(mem_addr), int'(pc));
      if (e_rd && k == 3) chk("R9", "operand addr", int'(mem_addr), int'(HL));
      if (e_done) begin
        chk(tag_t, "cost", int'(cyc_cost),
            !is_mem ? 8 : ((grp == 1) ? 12 : 15));
        chk("R2", "pc_next", int'(pc_next), (int'(pc) + 1) % 65536);
        if (e_rwe) begin
          chk("R3", "reg_sel", int'(reg_sel), tgt);
          chk(tag_d, $sformatf("op %02h reg data", op), int'(reg_wdata), r);
        end
        if (e_mwe) begin
          chk("R9", "wb addr", int'(mem_addr), int'(HL));
          chk(tag_d, $sformatf("op %02h mem data", op), int'(mem_wdata), r);
        end
        if (e_fwe) chk(tag_d, $sformatf("op %02h flags", op), int'(flags_out), ef);
      end
    end

    if (grp != 1) begin
      if (is_mem) m_mem[HL[7:0]] = r;
      else        m_regs[tgt]    = r;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    start    = 1'b0;
    pc_in    = '0;
    hl_in    = HL;
    flags_in = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      m_mem[i] = (i * 7 + 3) % 256;
    end
    for (int i = 0; i < 8; i++) set_reg(i, (i * 53 + 17) % 256);
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", int'({mem_rd, mem_we, reg_we, flags_we, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "strobes after reset", int'({mem_rd, mem_we, reg_we, flags_we, done}), 0);

    // directed corner cases
    set_reg(0, 'h85);
    run_op(8'h00, 8'h00, 16'h4010, 1'b0);   // R4 rotate left circular on B
    set_reg(1, 'h00);
    run_op(8'h31, 8'h01, 16'h4011, 1'b0);   // R5 logical left on C = 0
    set_reg(4, 'h80);
    run_op(8'h7C, 8'h01, 16'h4012, 1'b0);   // R6 test bit 7 of H
    m_mem[HL[7:0]] = 'hF7; mem[HL[7:0]] = 8'hF7;
    run_op(8'h5E, 8'h28, 16'h4013, 1'b0);   // R10 test bit 3 of memory
    set_reg(7, 'hFF);
    run_op(8'hBF, 8'hFF, 16'h4014, 1'b0);   // R7 clear bit 7 of A
    run_op(8'hC6, 8'h00, 16'h4015, 1'b0);   // R7/R9 set bit 0 of memory
    run_op(8'h1E, 8'h01, 16'h4016, 1'b0);   // R9 rotate right through carry, memory
    set_reg(0, 'h80);
    run_op(8'h20, 8'h00, 16'h4017, 1'b0);   // R4 arithmetic left 0x80 -> 0, carry
    run_op(8'h06, 8'h00, 16'h4018, 1'b1);   // R11 start held during memory op
    run_op(8'h47, 8'h00, 16'hFFFF, 1'b1);   // R11 held start, pc wrap for R2

    // every opcode
    for (int i = 0; i < 256; i++)
      run_op(8'(i), 8'((i * 37) ^ 'h5A), 16'h4000 | 16'(i % 128), 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule